// File: doc/BRIEF.md
# Nonvolatile Memory Command Status Register

This block is the 8-bit status and control register in front of a nonvolatile memory command engine. Software writes a 1 into the completion flag to start a command. The register then holds the flag low until the engine reports that the command has finished or was rejected. Three error flags capture an access error, a protection violation and a read collision. Each error flag is cleared by software writing a 1 to it. While an access error or protection violation is pending, new command launches are refused. Writes to the emulated-EEPROM RAM are refused as well.

The register sits at one address of a simple write bus, and its current value is presented continuously on a read port. Sideband inputs from the surrounding controller report these events: the end of reset initialization, command completion, command violation, error events, array reads and emulated-EEPROM RAM write attempts. The register answers with a launch pulse to the command engine, an acceptance strobe for RAM writes and a completion interrupt.

Top module: `nvm_cmd_status`

## Requirements
- R1: After reset every bit of `status_rd` reads 0, `launch_pulse` and `irq` are 0, and bit 7 stays 0 until `init_done` is seen.
- R2: A cycle with `init_done` high during the initialization phase sets bit 7 (completion flag) at that clock edge.
- R3: A register write with bit 7 = 1, while bit 7 reads 1 and neither bit 5 nor bit 4 is pending, clears bit 7 and raises `launch_pulse` for exactly the following cycle. Bit 7 then stays 0 until `cmd_done` or `cmd_viol` arrives.
- R4: A write of 1 to bit 7 while bit 7 reads 0 is ignored: no launch pulse, and bit 7 stays 0.
- R5: While bit 5 (access error) or bit 4 (protection violation) is set, a write of 1 to bit 7 produces no launch pulse, and bit 7 stays 1.
- R6: A single write that sets bit 7 together with the pending error bits clears those errors and launches in the same cycle.
- R7: Bits 6, 5 and 4 are cleared only by writing 1 to them; writing 0 leaves them unchanged. Bits 3 to 1 always read 0 whatever is written.
- R8: When a hardware set and a software clear of the same error bit fall in the same cycle, the bit ends up set.
- R9: `rd_req` while bit 7 reads 0 sets bit 6 (read collision); `rd_req` while bit 7 reads 1 has no effect.
- R10: `ee_wr_ack` is high in the same cycle as `ee_wr_req` only when `ee_ready` is high and bits 5 and 4 are clear. An accepted write clears bit 7 until `rec_done` arrives.
- R11: Bit 0 is read only and holds the value of `mod_stat_in` captured when a running command ends.
- R12: `irq` is high exactly when bit 7 is 1 and `irq_en` is high.
- R13: Writes whose address differs from `REG_ADDR` leave the register unchanged and launch nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data |
| status_rd | output | 8 | Current register value |
| init_done | input | 1 | Reset initialization sequence finished |
| cmd_done | input | 1 | Command engine finished a command |
| cmd_viol | input | 1 | Command engine rejected a command |
| mod_stat_in | input | 1 | Engine status bit captured at command end |
| acc_err_in | input | 1 | Access error event |
| prot_err_in | input | 1 | Protection violation event |
| rd_req | input | 1 | Read access to the memory array |
| ee_ready | input | 1 | Emulated-EEPROM mode ready |
| ee_wr_req | input | 1 | Write attempt to emulated-EEPROM RAM |
| rec_done | input | 1 | File system created the data record |
| irq_en | input | 1 | Completion interrupt enable |
| launch_pulse | output | 1 | One-cycle command start to the engine |
| ee_wr_ack | output | 1 | Emulated-EEPROM RAM write accepted |
| irq | output | 1 | Completion interrupt |

## Verification
Two pairs of functions can fall in the same cycle here. The first pair is a software clear of an error bit and the launch request carried in the same write. The bench drives a single write of 0xA0 with an access error pending and expects a launch pulse and a cleared error. The second pair is a hardware error event and the software clear of that same bit. The bench raises `acc_err_in` in the very cycle it writes 1 to bit 5 and expects bit 5 still set afterwards.

// File: rtl/nvm_stat_pkg.sv
package nvm_stat_pkg;
   localparam int REG_W  = 8;
   localparam int BIT_CC = 7;
   localparam int BIT_RC = 6;
   localparam int BIT_AE = 5;
   localparam int BIT_PV = 4;
   localparam int BIT_MS = 0;
   localparam int N_ERR  = 3;

   typedef struct packed {
      logic       cc;
      logic       rc;
      logic       ae;
      logic       pv;
      logic [2:0] rsvd;
      logic       ms;
   } stat_reg_t;
endpackage

// File: rtl/nvm_w1c_flag.sv
module nvm_w1c_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (hw_set) q <= 1'b1;
      else if (sw_clr) q <= 1'b0;
   end
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl #(
   parameter bit LAUNCH_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init_done,
   input  logic wr_go,
   input  logic err_after,
   input  logic done_evt,
   input  logic ee_take,
   input  logic rec_done,
   input  logic mod_stat_in,
   output logic cc_q,
   output logic ms_q,
   output logic launch_pulse
);
   logic init_pend;
   logic launch_ok;
   logic cc_nxt;

   assign launch_ok = wr_go & cc_q & ~err_after & ~init_pend;

   always_comb begin
      if (init_pend)  cc_nxt = init_done;
      else if (cc_q)  cc_nxt = ~(launch_ok | ee_take);
      else            cc_nxt = done_evt | rec_done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_pend <= 1'b1;
         cc_q      <= 1'b0;
         ms_q      <= 1'b0;
      end else begin
         if (init_pend && init_done) init_pend <= 1'b0;
         cc_q <= cc_nxt;
         if (done_evt && !cc_q && !init_pend) ms_q <= mod_stat_in;
      end
   end

   generate
      if (LAUNCH_REG) begin : g_launch_reg
         logic launch_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) launch_r <= 1'b0;
            else        launch_r <= launch_ok;
         end
         assign launch_pulse = launch_r;
      end else begin : g_launch_comb
         assign launch_pulse = launch_ok;
      end
   endgenerate
endmodule

// File: rtl/nvm_cmd_status.sv
module nvm_cmd_status
   import nvm_stat_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int REG_ADDR   = 0,
   parameter bit LAUNCH_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  status_rd,
   input  logic              init_done,
   input  logic              cmd_done,
   input  logic              cmd_viol,
   input  logic              mod_stat_in,
   input  logic              acc_err_in,
   input  logic              prot_err_in,
   input  logic              rd_req,
   input  logic              ee_ready,
   input  logic              ee_wr_req,
   input  logic              rec_done,
   input  logic              irq_en,
   output logic              launch_pulse,
   output logic              ee_wr_ack,
   output logic              irq
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("nvm_cmd_status: ADDR_W out of range");
      end
      if (REG_ADDR < 0 || REG_ADDR >= ADDR_SPAN) begin : g_bad_reg_addr
         $error("nvm_cmd_status: REG_ADDR outside address space");
      end
   endgenerate

   logic             hit;
   logic [N_ERR-1:0] err_set;
   logic [N_ERR-1:0] err_clr;
   logic [N_ERR-1:0] err_q;
   logic             cc_q, ms_q;
   logic             err_after;
   logic             unused_bits;
   stat_reg_t        sr;

   assign hit = wr_en && (wr_addr == ADDR_W'(REG_ADDR));
   assign unused_bits = ^wr_data[3:0];

   // err index 2: collision, 1: access error, 0: protection violation
   assign err_set = {rd_req & ~cc_q, acc_err_in, prot_err_in};
   assign err_clr = {N_ERR{hit}} & {wr_data[BIT_RC], wr_data[BIT_AE], wr_data[BIT_PV]};

   generate
      for (genvar i = 0; i < N_ERR; i++) begin : g_err
         nvm_w1c_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (err_set[i]),
            .sw_clr (err_clr[i]),
            .q      (err_q[i])
         );
      end
   endgenerate

   assign err_after = (err_q[1] & ~err_clr[1]) | (err_q[0] & ~err_clr[0]);
   assign ee_wr_ack = ee_wr_req & ee_ready & ~err_q[1] & ~err_q[0];

   nvm_cmd_ctrl #(.LAUNCH_REG(LAUNCH_REG)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .init_done    (init_done),
      .wr_go        (hit & wr_data[BIT_CC]),
      .err_after    (err_after),
      .done_evt     (cmd_done | cmd_viol),
      .ee_take      (ee_wr_ack),
      .rec_done     (rec_done),
      .mod_stat_in  (mod_stat_in),
      .cc_q         (cc_q),
      .ms_q         (ms_q),
      .launch_pulse (launch_pulse)
   );

   always_comb begin
      sr      = '0;
      sr.cc   = cc_q;
      sr.rc   = err_q[2];
      sr.ae   = err_q[1];
      sr.pv   = err_q[0];
      sr.ms   = ms_q;
   end

   assign status_rd = sr;
   assign irq       = cc_q & irq_en;
endmodule

// File: rtl/nvm_cmd_status_chk.sv
module nvm_cmd_status_chk #(
   parameter int ADDR_W     = 4,
   parameter int REG_ADDR   = 0,
   parameter bit LAUNCH_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_b7,
   input logic [7:0]        status_rd,
   input logic              launch_pulse,
   input logic              acc_err_in,
   input logic              rd_req,
   input logic              ee_wr_ack,
   input logic              irq
);
   logic hit;
   assign hit = wr_en && (wr_addr == ADDR_W'(REG_ADDR));

   generate
      if (LAUNCH_REG) begin : g_reg_chk
         // R3
         launch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            launch_pulse |-> !status_rd[7]);
         // R4
         busy_nolaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && wr_b7 && !status_rd[7]) |=> !launch_pulse);
      end
   endgenerate

   // R8
   hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err_in |=> status_rd[5]);

   // R9
   collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !status_rd[7]) |=> status_rd[6]);

   // R10
   ee_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_wr_ack && status_rd[7]) |=> !status_rd[7]);

   // R12
   irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> status_rd[7]);
endmodule

bind nvm_cmd_status nvm_cmd_status_chk #(
   .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .LAUNCH_REG(LAUNCH_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_addr      (wr_addr),
   .wr_b7        (wr_data[7]),
   .status_rd    (status_rd),
   .launch_pulse (launch_pulse),
   .acc_err_in   (acc_err_in),
   .rd_req       (rd_req),
   .ee_wr_ack    (ee_wr_ack),
   .irq          (irq)
);

// File: tb/nvm_cmd_status_tb.sv
module nvm_cmd_status_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 4;

   logic clk = 0, rst_n = 0;
   logic wr_en = 0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] status_rd;
   logic init_done = 0, cmd_done = 0, cmd_viol = 0, mod_stat_in = 0;
   logic acc_err_in = 0, prot_err_in = 0, rd_req = 0;
   logic ee_ready = 0, ee_wr_req = 0, rec_done = 0, irq_en = 0;
   logic launch_pulse, ee_wr_ack, irq;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nvm_cmd_status #(.ADDR_W(ADDR_W), .REG_ADDR(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .status_rd(status_rd), .init_done(init_done), .cmd_done(cmd_done),
      .cmd_viol(cmd_viol), .mod_stat_in(mod_stat_in), .acc_err_in(acc_err_in),
      .prot_err_in(prot_err_in), .rd_req(rd_req), .ee_ready(ee_ready),
      .ee_wr_req(ee_wr_req), .rec_done(rec_done), .irq_en(irq_en),
      .launch_pulse(launch_pulse), .ee_wr_ack(ee_wr_ack), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0; wr_data = '0;
   endtask

   task automatic t_reset;
      chk("R1 status", status_rd, 8'h00);
      chk("R1 launch", {7'd0, launch_pulse}, 8'h0);
      chk("R1 irq", {7'd0, irq}, 8'h0);
      repeat (3) @(negedge clk);
      chk("R1 held before init", status_rd, 8'h00);
   endtask

   task automatic t_init;
      @(negedge clk); init_done = 1;
      @(negedge clk); init_done = 0;
      chk("R2 init sets cc", status_rd, 8'h80);
      chk("R12 irq disabled", {7'd0, irq}, 8'h0);
      irq_en = 1; #1;
      chk("R12 irq enabled", {7'd0, irq}, 8'h1);
   endtask

   task automatic t_launch;
      reg_wr(0, 8'h80);
      chk("R3 launch pulse", {7'd0, launch_pulse}, 8'h1);
      chk("R3 cc cleared", status_rd, 8'h00);
      chk("R12 irq low while busy", {7'd0, irq}, 8'h0);
      @(negedge clk);
      chk("R3 pulse one cycle", {7'd0, launch_pulse}, 8'h0);
      reg_wr(0, 8'h80);
      chk("R4 busy write no launch", {7'd0, launch_pulse}, 8'h0);
      chk("R4 cc stays 0", status_rd, 8'h00);
      @(negedge clk); cmd_done = 1; mod_stat_in = 1;
      @(negedge clk); cmd_done = 0; mod_stat_in = 0;
      chk("R3 R11 done sets cc, captures status", status_rd, 8'h81);
   endtask

   task automatic t_block;
      @(negedge clk); acc_err_in = 1;
      @(negedge clk); acc_err_in = 0;
      chk("R5 access error set", status_rd, 8'hA1);
      reg_wr(0, 8'h80);
      chk("R5 blocked launch", {7'd0, launch_pulse}, 8'h0);
      chk("R5 cc stays 1", status_rd, 8'hA1);
      @(negedge clk); ee_ready = 1; ee_wr_req = 1; #1;
      chk("R10 ee write refused on error", {7'd0, ee_wr_ack}, 8'h0);
      @(negedge clk); ee_wr_req = 0;
      chk("R10 refused write keeps cc", status_rd, 8'hA1);
   endtask

   task automatic t_clear_launch;
      reg_wr(0, 8'hA0);
      chk("R6 clear and launch", {7'd0, launch_pulse}, 8'h1);
      chk("R6 status", status_rd, 8'h01);
      @(negedge clk); cmd_done = 1;
      @(negedge clk); cmd_done = 0;
      chk("R11 capture 0", status_rd, 8'h80);
   endtask

   task automatic t_w1c;
      @(negedge clk); prot_err_in = 1;
      @(negedge clk); prot_err_in = 0;
      chk("R7 prot set", status_rd, 8'h90);
      reg_wr(0, 8'h0F);
      chk("R7 zeros keep flags, rsvd 0", status_rd, 8'h90);
      reg_wr(3, 8'hF0);
      chk("R13 other address ignored", status_rd, 8'h90);
      chk("R13 no launch", {7'd0, launch_pulse}, 8'h0);
      reg_wr(0, 8'h10);
      chk("R7 w1c prot", status_rd, 8'h80);
   endtask

   task automatic t_race;
      @(negedge clk);
      acc_err_in = 1; wr_en = 1; wr_addr = 0; wr_data = 8'h20;
      @(negedge clk);
      acc_err_in = 0; wr_en = 0; wr_data = 0;
      chk("R8 hw set wins", status_rd, 8'hA0);
      reg_wr(0, 8'h20);
      chk("R7 w1c access", status_rd, 8'h80);
   endtask

   task automatic t_collide;
      @(negedge clk); rd_req = 1;
      @(negedge clk); rd_req = 0;
      chk("R9 no collision when idle", status_rd, 8'h80);
      reg_wr(0, 8'h80);
      chk("R3 launch again", {7'd0, launch_pulse}, 8'h1);
      @(negedge clk); rd_req = 1;
      @(negedge clk); rd_req = 0;
      chk("R9 collision while busy", status_rd, 8'h40);
      @(negedge clk); cmd_viol = 1;
      @(negedge clk); cmd_viol = 0;
      chk("R3 violation ends command", status_rd, 8'hC0);
      reg_wr(0, 8'h40);
      chk("R7 w1c collision", status_rd, 8'h80);
   endtask

   task automatic t_ee;
      @(negedge clk); ee_ready = 1; ee_wr_req = 1; #1;
      chk("R10 ee write accepted", {7'd0, ee_wr_ack}, 8'h1);
      @(negedge clk); ee_wr_req = 0;
      chk("R10 cc cleared by ee write", status_rd, 8'h00);
      reg_wr(0, 8'h80);
      chk("R4 no launch during record", {7'd0, launch_pulse}, 8'h0);
      @(negedge clk); rec_done = 1;
      @(negedge clk); rec_done = 0;
      chk("R10 record done sets cc", status_rd, 8'h80);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_init();
      t_launch();
      t_block();
      t_clear_launch();
      t_w1c();
      t_race();
      t_collide();
      t_ee();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule